// File: doc/BRIEF.md
# Flash ECC Engine Register Front End

This block is the register-level control face of a flash-page error-correction engine. It has two channels, an encoder and a decoder. Software drives both through single-cycle read and write strobes. Each channel has a run control, a configuration word and an idle flag. Each also has an interrupt-enable word and an interrupt-status word. The decoder adds a per-sector completion bitmask and a bank of per-sector error-count lanes. A single interrupt line is the merged request of both channels.

The arithmetic core is replaced by a sector timer. Once a channel is started, the timer finishes one sector every `SECT_CYC` cycles. The encoder always handles one sector. The decoder handles the number of sectors programmed in its configuration word. Per-sector error counts arrive on an input port and are captured when each decoded sector finishes. The configuration words are stored in full. Software packs into them a strength index, a mode bit and a message size: the decoder's size is the data bits plus 14 parity bits per correctable bit, while the encoder's size is data bits only.

Top module: `flash_ecc_csr`

## Requirements
- R1: The encoder config (0x004), encoder input address (0x008) and decoder config (0x104) read back every written bit. Decoder config bits [8+:SECT_W] hold the sector count minus one. Bit 5 is the mode: 0 is direct-memory and 1 is flash-interface.
- R2: Bit 0 of the idle words (encoder 0x00C, decoder 0x10C) reads 1 after reset. It reads 0 from the edge that samples a write of 1 to the channel control (encoder 0x000, decoder 0x100). It reads 1 again once the channel's last sector has finished.
- R3: A write of 0 to a channel control stops the channel. Its idle bit is 1 after that edge, and no later sector completion is recorded.
- R4: An encode in direct-memory mode sets encoder status bit 0 (0x084). With encoder enable bit 0 (0x080) set, irq_o rises exactly SECT_CYC cycles after the edge that sampled the start write.
- R5: An encode in flash-interface mode never sets encoder status.
- R6: A read of a status word (0x084 or 0x204) returns its value and clears it. The next read returns 0.
- R7: In the decode-done word (0x124), bit i is set when decoded sector i finishes. The whole word clears when the decoder is started.
- R8: Decoder status (0x204 bit 0) is set on every finished sector. The exception is when decoder enable bit 1 (0x200) is set and the mode is flash-interface: then only the last sector sets it. In direct-memory mode bit 1 has no effect.
- R9: The error words start at 0x114 and each holds four 8-bit lanes. Sector i sits in word i/4, lane i%4 (bits 8*(i%4)+7:8*(i%4)). A lane captures err_cnt_i[i*ERR_W+:ERR_W] when sector i finishes. All lanes clear on decoder start.
- R10: irq_o is the OR, over both channels, of status AND enable bit 0. A write of 0 to an enable word drops irq_o after that edge, and the status is held.
- R11: A read of the decode-done word also clears decoder status.
- R12: Read data appears on rdata_o on the cycle after rd_en_i is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| err_cnt_i | input | MAX_SECT*ERR_W | Per-sector error counts from the core |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Merged interrupt request |

## Verification
A stuck or stale status bit appears on irq_o within one cycle. It appears in the next status read two cycles after the strobe. A wrong sector timer or a wrong last-sector compare moves the exact cycle at which irq_o rises, and the bench measures that cycle to the edge. A wrong page-select decode shows as an early interrupt partway through a page. A wrong lane or done-bit index shows as a misplaced byte or bit in the error and done words, which are read right after the page ends and after a restart.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned MODE_BIT = 5;
  localparam int unsigned SECT_POS = 8;

  localparam logic [ADDR_W-1:0] OFS_ENC_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_ENC_CFG   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_ENC_ADDR  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ENC_IDLE  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ENC_IEN   = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_ENC_ISTAT = 12'h084;
  localparam logic [ADDR_W-1:0] OFS_DEC_CTRL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_DEC_CFG   = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_DEC_IDLE  = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_DEC_ERR0  = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_DEC_DONE  = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_DEC_IEN   = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_DEC_ISTAT = 12'h204;

  typedef struct packed {
    logic page_sel;
    logic en;
  } irq_en_t;
endpackage

// File: rtl/ecc_sector_stub.sv
module ecc_sector_stub #(
  parameter int unsigned SECT_CYC = 16,
  parameter int unsigned MAX_SECT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [SECT_W-1:0]   nsect_m1_i,
  output logic                active_o,
  output logic                done_o,
  output logic                last_o,
  output logic [SECT_W-1:0]   idx_o
);
  localparam int unsigned SECT_W = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;
  localparam int unsigned CYC_W  = (SECT_CYC > 1) ? $clog2(SECT_CYC) : 1;

  logic [CYC_W-1:0]  cyc_q;
  logic [SECT_W-1:0] idx_q, lim_q;
  logic              act_q;

  assign done_o   = act_q && (cyc_q == CYC_W'(SECT_CYC - 1));
  assign last_o   = done_o && (idx_q == lim_q);
  assign idx_o    = idx_q;
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cyc_q <= '0;
      idx_q <= '0;
      lim_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cyc_q <= '0;
      idx_q <= '0;
      lim_q <= nsect_m1_i;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (done_o) begin
      cyc_q <= '0;
      if (idx_q == lim_q) act_q <= 1'b0;
      else                idx_q <= idx_q + 1'b1;
    end else if (act_q) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_irq_chan.sv
module ecc_irq_chan
  import flash_ecc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_wr_i,
  input  logic [1:0] en_wdata_i,
  input  logic       evt_i,
  input  logic       clr_i,
  output irq_en_t    en_o,
  output logic       status_o,
  output logic       irq_o
);
  irq_en_t en_q;
  logic    st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= irq_en_t'(en_wdata_i);
      // a new event wins over a read-clear in the same cycle
      if (evt_i)      st_q <= 1'b1;
      else if (clr_i) st_q <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign status_o = st_q;
  assign irq_o    = st_q && en_q.en;
endmodule

// File: rtl/flash_ecc_csr.sv
module flash_ecc_csr
  import flash_ecc_pkg::*;
#(
  parameter int unsigned SECT_CYC = 16,
  parameter int unsigned MAX_SECT = 8,
  parameter int unsigned ERR_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [MAX_SECT*ERR_W-1:0] err_cnt_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      irq_o
);
  localparam int unsigned SECT_W    = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;
  localparam int unsigned ERR_WORDS = (MAX_SECT + LANES - 1) / LANES;
  localparam int unsigned SLOTS     = ERR_WORDS * LANES;
  localparam logic [ADDR_W-1:0] ERR_END = OFS_DEC_ERR0 + ADDR_W'(4 * ERR_WORDS);

  // write decode
  logic wr_enc_ctrl, wr_dec_ctrl;
  logic enc_start, enc_stop, dec_start, dec_stop;
  assign wr_enc_ctrl = wr_en_i && (addr_i == OFS_ENC_CTRL);
  assign wr_dec_ctrl = wr_en_i && (addr_i == OFS_DEC_CTRL);
  assign enc_start   = wr_enc_ctrl &&  wdata_i[0];
  assign enc_stop    = wr_enc_ctrl && !wdata_i[0];
  assign dec_start   = wr_dec_ctrl &&  wdata_i[0];
  assign dec_stop    = wr_dec_ctrl && !wdata_i[0];

  logic              enc_run, dec_run;
  logic [DATA_W-1:0] enc_cfg, enc_addr, dec_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_run  <= 1'b0;
      dec_run  <= 1'b0;
      enc_cfg  <= '0;
      enc_addr <= '0;
      dec_cfg  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_ENC_CTRL: enc_run  <= wdata_i[0];
        OFS_DEC_CTRL: dec_run  <= wdata_i[0];
        OFS_ENC_CFG:  enc_cfg  <= wdata_i;
        OFS_ENC_ADDR: enc_addr <= wdata_i;
        OFS_DEC_CFG:  dec_cfg  <= wdata_i;
        default: ;
      endcase
    end
  end

  // sector timers
  logic              enc_busy, enc_done, enc_last;
  logic [0:0]        enc_idx;
  logic              dec_busy, dec_done, dec_last;
  logic [SECT_W-1:0] dec_idx;

  ecc_sector_stub #(.SECT_CYC(SECT_CYC), .MAX_SECT(2)) i_enc_core (
    .clk_i, .rst_ni,
    .start_i(enc_start), .stop_i(enc_stop), .nsect_m1_i(1'b0),
    .active_o(enc_busy), .done_o(enc_done), .last_o(enc_last), .idx_o(enc_idx)
  );

  ecc_sector_stub #(.SECT_CYC(SECT_CYC), .MAX_SECT(MAX_SECT)) i_dec_core (
    .clk_i, .rst_ni,
    .start_i(dec_start), .stop_i(dec_stop),
    .nsect_m1_i(dec_cfg[SECT_POS +: SECT_W]),
    .active_o(dec_busy), .done_o(dec_done), .last_o(dec_last), .idx_o(dec_idx)
  );

  // interrupt channels
  irq_en_t enc_ien, dec_ien;
  logic    enc_stat, dec_stat, enc_irq, dec_irq;
  logic    enc_evt, dec_evt, dec_pg;

  assign enc_evt = enc_done && enc_last && (enc_idx == 1'b0) && !enc_cfg[MODE_BIT];
  assign dec_pg  = dec_ien.page_sel && dec_cfg[MODE_BIT];
  assign dec_evt = dec_done && (!dec_pg || dec_last);

  ecc_irq_chan i_enc_irq (
    .clk_i, .rst_ni,
    .en_wr_i(wr_en_i && (addr_i == OFS_ENC_IEN)), .en_wdata_i(wdata_i[1:0]),
    .evt_i(enc_evt), .clr_i(rd_en_i && (addr_i == OFS_ENC_ISTAT)),
    .en_o(enc_ien), .status_o(enc_stat), .irq_o(enc_irq)
  );

  ecc_irq_chan i_dec_irq (
    .clk_i, .rst_ni,
    .en_wr_i(wr_en_i && (addr_i == OFS_DEC_IEN)), .en_wdata_i(wdata_i[1:0]),
    .evt_i(dec_evt),
    .clr_i(rd_en_i && ((addr_i == OFS_DEC_ISTAT) || (addr_i == OFS_DEC_DONE))),
    .en_o(dec_ien), .status_o(dec_stat), .irq_o(dec_irq)
  );

  assign irq_o = enc_irq || dec_irq;

  // per-sector completion mask
  logic [MAX_SECT-1:0] done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        done_q <= '0;
    else if (dec_start) done_q <= '0;
    else if (dec_done)  done_q[dec_idx] <= 1'b1;
  end

  // error-count lanes, padded to whole words
  logic [LANE_W-1:0] err_lane [SLOTS];
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < MAX_SECT) begin : g_live
      logic [ERR_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (dec_start)                           q <= '0;
        else if (dec_done && dec_idx == SECT_W'(s))   q <= err_cnt_i[s*ERR_W +: ERR_W];
      end
      assign err_lane[s] = LANE_W'(q);
    end else begin : g_pad
      assign err_lane[s] = '0;
    end
  end

  logic              err_hit;
  logic [DATA_W-1:0] err_val;
  int unsigned       err_word;
  assign err_hit = (addr_i >= OFS_DEC_ERR0) && (addr_i < ERR_END) && (addr_i[1:0] == 2'b00);

  always_comb begin
    err_val  = '0;
    err_word = int'(addr_i - OFS_DEC_ERR0) >> 2;
    if (err_hit) begin
      for (int l = 0; l < LANES; l++) begin
        err_val[l*LANE_W +: LANE_W] = err_lane[err_word*LANES + l];
      end
    end
  end

  // read mux and registered data
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_ENC_CTRL:  rd_mux[0] = enc_run;
      OFS_ENC_CFG:   rd_mux    = enc_cfg;
      OFS_ENC_ADDR:  rd_mux    = enc_addr;
      OFS_ENC_IDLE:  rd_mux[0] = !enc_busy;
      OFS_ENC_IEN:   rd_mux[1:0] = enc_ien;
      OFS_ENC_ISTAT: rd_mux[0] = enc_stat;
      OFS_DEC_CTRL:  rd_mux[0] = dec_run;
      OFS_DEC_CFG:   rd_mux    = dec_cfg;
      OFS_DEC_IDLE:  rd_mux[0] = !dec_busy;
      OFS_DEC_DONE:  rd_mux[MAX_SECT-1:0] = done_q;
      OFS_DEC_IEN:   rd_mux[1:0] = dec_ien;
      OFS_DEC_ISTAT: rd_mux[0] = dec_stat;
      default:       rd_mux    = err_val;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/flash_ecc_csr_chk.sv
module flash_ecc_csr_chk
  import flash_ecc_pkg::*;
#(
  parameter int unsigned MAX_SECT = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                irq_o,
  input logic                enc_busy_i,
  input logic                dec_busy_i,
  input logic [MAX_SECT-1:0] done_i,
  input logic                dec_stat_i,
  input logic                dec_pg_i
);
  // R2
  dec_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DEC_CTRL && wdata_i[0]) |=> dec_busy_i);

  // R3
  enc_stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_ENC_CTRL && !wdata_i[0]) |=> !enc_busy_i);

  // R7
  done_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_DEC_CTRL && wdata_i[0]) |=> ((done_i & $past(done_i)) == $past(done_i)));

  // R10
  irq_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i || rd_en_i));

  // R8
  page_irq_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_stat_i) && $past(dec_pg_i)) |-> !dec_busy_i);
endmodule

bind flash_ecc_csr flash_ecc_csr_chk #(.MAX_SECT(MAX_SECT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .enc_busy_i(enc_busy), .dec_busy_i(dec_busy), .done_i(done_q),
  .dec_stat_i(dec_stat), .dec_pg_i(dec_pg)
);

// File: tb/test_flash_ecc_csr.sv
module test_flash_ecc_csr;
  localparam int C  = 16;
  localparam int NS = 8;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [NS*EW-1:0] err_cnt;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_ecc_csr #(.SECT_CYC(C), .MAX_SECT(NS), .ERR_W(EW)) i_flash_ecc_csr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .err_cnt_i(err_cnt),
    .rdata_o(rdata), .irq_o(irq)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected word
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // monitor: R12 read data is valid the cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rdata, e);
    end
  end

  function automatic logic [31:0] dcfg(input int sect, input bit flash, input int bytes, input int strength_idx, input int strength);
    logic [31:0] v;
    v = 32'(1) << 31;
    v |= 32'((bytes * 8 + strength * 14) & 16'h7FFF) << 16;
    v |= 32'(3) << 12;
    v |= 32'(sect - 1) << 8;
    v |= 32'(flash) << 5;
    v |= 32'(strength_idx);
    return v;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    for (int s = 0; s < NS; s++) err_cnt[s*EW +: EW] = EW'(s * 3 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R10 reset irq", 32'(irq), 32'd0);
    rd(12'h00C, 32'd1, "R2 reset enc idle");
    rd(12'h10C, 32'd1, "R2 reset dec idle");
    rd(12'h124, 32'd0, "R7 reset done");
    rd(12'h000, 32'd0, "R12 reset enc ctrl");

    // R1 readback
    wr(12'h004, 32'hABCD_0021);
    wr(12'h008, 32'h8000_1234);
    wr(12'h104, dcfg(4, 1'b1, 512, 3, 8));
    rd(12'h004, 32'hABCD_0021, "R1 enc cfg");
    rd(12'h008, 32'h8000_1234, "R1 enc addr");
    rd(12'h104, dcfg(4, 1'b1, 512, 3, 8), "R1 dec cfg");

    // R4 encoder direct mode
    wr(12'h004, 32'h1000_0002);
    wr(12'h080, 32'd1);
    wr(12'h000, 32'd1);
    n = 0;
    while (!irq) begin @(negedge clk); n++; end
    chk("R4 enc irq latency", 32'(n), 32'(C));
    rd(12'h00C, 32'd1, "R2 enc idle after sector");
    rd(12'h084, 32'd1, "R6 enc status set");
    chk("R6 irq after read clear", 32'(irq), 32'd0);
    rd(12'h084, 32'd0, "R6 enc status cleared");
    wr(12'h000, 32'd0);

    // R5 encoder flash mode
    wr(12'h004, 32'h1000_0022);
    wr(12'h000, 32'd1);
    rd(12'h00C, 32'd0, "R2 enc busy");
    repeat (C + 4) @(negedge clk);
    rd(12'h00C, 32'd1, "R2 enc idle flash");
    rd(12'h084, 32'd0, "R5 no enc status in flash mode");
    chk("R5 no irq", 32'(irq), 32'd0);
    wr(12'h000, 32'd0);

    // decoder, per-sector interrupts, 4 sectors
    wr(12'h200, 32'd1);
    wr(12'h104, dcfg(4, 1'b1, 512, 3, 8));
    wr(12'h100, 32'd1);
    n = 0;
    while (!irq) begin @(negedge clk); n++; end
    chk("R8 first sector irq latency", 32'(n), 32'(C));
    rd(12'h204, 32'd1, "R6 dec status set");
    rd(12'h204, 32'd0, "R6 dec status cleared");
    repeat (4 * C) @(negedge clk);
    chk("R10 irq pending", 32'(irq), 32'd1);
    rd(12'h124, 32'h0000_000F, "R7 done mask 4 sectors");
    rd(12'h10C, 32'd1, "R2 dec idle");
    chk("R11 irq after done read", 32'(irq), 32'd0);
    rd(12'h204, 32'd0, "R11 status cleared by done read");
    rd(12'h114, 32'h0A07_0401, "R9 err word0");
    rd(12'h118, 32'd0, "R9 err word1 untouched");

    // restart then stop mid page
    wr(12'h100, 32'd1);
    repeat (C + C / 2) @(negedge clk);
    rd(12'h124, 32'd1, "R7 mask cleared on start");
    rd(12'h114, 32'd1, "R9 lanes cleared on start");
    wr(12'h100, 32'd0);
    rd(12'h10C, 32'd1, "R3 idle after stop");
    repeat (3 * C) @(negedge clk);
    rd(12'h124, 32'd1, "R3 no completion after stop");

    // R8 page select in flash mode
    wr(12'h200, 32'd3);
    wr(12'h100, 32'd1);
    repeat (2 * C) @(negedge clk);
    rd(12'h204, 32'd0, "R8 no status mid page");
    chk("R8 no irq mid page", 32'(irq), 32'd0);
    n = 0;
    while (!irq) begin @(negedge clk); n++; end
    chk("R8 page irq at last sector", 32'(n), 32'(4 * C - (2 * C + 2)));
    wr(12'h200, 32'd0);
    chk("R10 mask drops irq", 32'(irq), 32'd0);
    rd(12'h204, 32'd1, "R10 status held while masked");
    wr(12'h100, 32'd0);

    // R8 page select ignored in direct mode
    wr(12'h104, dcfg(2, 1'b0, 512, 3, 8));
    wr(12'h200, 32'd3);
    wr(12'h100, 32'd1);
    n = 0;
    while (!irq) begin @(negedge clk); n++; end
    chk("R8 direct mode per sector irq", 32'(n), 32'(C));
    repeat (2 * C) @(negedge clk);
    rd(12'h10C, 32'd1, "R2 dec idle 2 sectors");
    rd(12'h124, 32'h0000_0003, "R7 done mask 2 sectors");
    wr(12'h100, 32'd0);

    // full page of NS sectors, interrupt masked
    wr(12'h200, 32'd0);
    wr(12'h104, dcfg(NS, 1'b1, 1024, 4, 12));
    wr(12'h100, 32'd1);
    repeat ((NS + 1) * C) @(negedge clk);
    rd(12'h124, 32'h0000_00FF, "R7 done mask full page");
    rd(12'h118, 32'h1613_100D, "R9 err word1 full page");
    chk("R10 masked no irq", 32'(irq), 32'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule